// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM with Double-Cycle Deselect

This block is a small synchronous single-port memory. The address, write data, the three chip selects and the write controls all pass through input registers on the rising clock edge. Writes complete from those registered values one clock later. Reads pass through an output register, so read data follows the address by a fixed pipeline delay.

A write may update any subset of the byte lanes. Each lane holds eight data bits and one parity bit. A global write input overrides the per-lane controls and stores the whole word.

The output-drive flag is held high for one extra cycle when a deselect follows a read. This lets several of these memories share a read bus without a wait state when the selected bank changes. The output enable gates that flag without waiting for a clock. The burst address is produced outside this block.

Top module: `pbw_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the output register is cleared to zero and `drive` is low on the following cycle.
- R2: A cycle is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 are all sampled at the same edge. Any other combination is a deselect: no lane is written and the output register keeps its value.
- R3: For a read sampled at edge k, the addressed word is on `rdata` and `drive` is high after edge k+1, so it can be sampled at edge k+2.
- R4: With `gw_n`=1 and `bw_en_n`=0, a selected cycle writes exactly those lanes i where `lane_we_n[i]`=0. Lane i occupies `wdata`/`rdata` bits [9i+8:9i], and all other lanes keep their old contents.
- R5: With `gw_n`=0, a selected cycle writes all lanes, whatever `bw_en_n` and `lane_we_n` hold.
- R6: A selected cycle with `gw_n`=1 and either `bw_en_n`=1 or `lane_we_n` all ones writes nothing and acts as a read.
- R7: A write sampled at edge k drops `drive` after edge k+1, even when the previous cycle was a read.
- R8: When a deselect is sampled at the edge after a read, `drive` stays high and `rdata` stays unchanged for one extra cycle. `drive` then goes low.
- R9: `oe_n`=1 forces `drive` low at once, with no clock edge needed. Returning `oe_n` to 0 restores the registered drive state at once.
- R10: A read sampled at the edge right after a write to the same address returns the newly merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write word, lane i at bits [9i+8:9i] |
| sel1_n | input | 1 | Primary chip select, active low |
| sel2 | input | 1 | Expansion chip select, active high |
| sel3_n | input | 1 | Expansion chip select, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| bw_en_n | input | 1 | Qualifier for the per-lane strobes, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read word |
| drive | output | 1 | High while the block drives its read data |

## Verification
The bench uses the default parameters: six address bits and four nine-bit lanes. With 64 words, a full behavioural mirror of the array fits easily in the bench. With four lanes, single-lane, alternating-lane, all-lane and qualifier-off write masks can all be reached, including the parity bit at the top of each lane. The nine-bit lane width places lane boundaries off byte alignment, so an off-by-one lane slice shows up in the merged words read back.

// File: rtl/pbw_pkg.sv
`timescale 1ns/1ps
package pbw_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Output-drive pipeline state: data-valid stage and the extra deselect stage.
    typedef struct packed {
        logic rd_v;
        logic lag;
    } drv_t;

    function automatic logic chip_selected(input logic s1_n, input logic s2, input logic s3_n);
        return !s1_n && s2 && !s3_n;
    endfunction

    function automatic logic lane_write(input logic gw_n, input logic bw_en_n, input logic we_n);
        return !gw_n || (!bw_en_n && !we_n);
    endfunction

endpackage

// File: rtl/pbw_in_stage.sv
`timescale 1ns/1ps
module pbw_in_stage #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      sel1_n,
    input  logic                      sel2,
    input  logic                      sel3_n,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic                      bw_en_n,
    input  logic                      gw_n,
    output pbw_pkg::op_e              op_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q,
    output logic [LANES-1:0]          mask_q
);
    import pbw_pkg::*;

    logic [LANES-1:0] mask_d;
    logic             sel_d;
    op_e              op_d;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign mask_d[g] = lane_write(gw_n, bw_en_n, lane_we_n[g]);
    end

    always_comb begin
        sel_d = chip_selected(sel1_n, sel2, sel3_n);
        if (!sel_d)
            op_d = OP_IDLE;
        else if (|mask_d)
            op_d = OP_WRITE;
        else
            op_d = OP_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            op_q    <= op_d;
            addr_q  <= addr;
            wdata_q <= wdata;
            mask_q  <= sel_d ? mask_d : '0;
        end
    end

endmodule

// File: rtl/pbw_array.sv
`timescale 1ns/1ps
module pbw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  pbw_pkg::op_e              op,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          mask,
    output logic [LANES*LANE_W-1:0]   rdata
);
    import pbw_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && mask[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (op == OP_READ)
                rdata[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end

endmodule

// File: rtl/pbw_drive_ctl.sv
`timescale 1ns/1ps
module pbw_drive_ctl (
    input  logic          clk,
    input  logic          rst,
    input  pbw_pkg::op_e  op,
    output pbw_pkg::drv_t st
);
    import pbw_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.rd_v <= (op == OP_READ);
            // Extra stage: a deselect right after a read keeps the drivers on one more cycle.
            st.lag  <= st.rd_v && (op == OP_IDLE);
        end
    end

endmodule

// File: rtl/pbw_sram.sv
`timescale 1ns/1ps
module pbw_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              bw_en_n,
    input  logic              gw_n,
    input  logic              oe_n,
    output logic [DW-1:0]     rdata,
    output logic              drive
);
    import pbw_pkg::*;

    op_e              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] mask_q;
    drv_t             dst;
    logic             drive_int;
    logic             dcd_lag;

    pbw_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .lane_we_n(lane_we_n), .bw_en_n(bw_en_n), .gw_n(gw_n),
        .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
    );

    pbw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst(rst), .op(op_q), .addr(addr_q),
        .wdata(wdata_q), .mask(mask_q), .rdata(rdata)
    );

    pbw_drive_ctl u_drv (
        .clk(clk), .rst(rst), .op(op_q), .st(dst)
    );

    assign dcd_lag   = dst.lag;
    assign drive_int = dst.rd_v || dcd_lag;
    assign drive     = drive_int && !oe_n;

endmodule

// File: rtl/pbw_sram_chk.sv
`timescale 1ns/1ps
module pbw_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          sel1_n,
    input logic          sel2,
    input logic          sel3_n,
    input pbw_pkg::op_e  op_q,
    input logic          drive_int,
    input logic          dcd_lag,
    input logic [DW-1:0] rdata
);
    import pbw_pkg::*;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!drive_int && rdata == '0));

    // R2
    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (sel1_n || !sel2 || sel3_n) |=> (op_q == OP_IDLE));

    // R3
    a_r3_read_drives: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_READ) |=> drive_int);

    // R7
    a_r7_write_off: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_WRITE) |=> !drive_int);

    // R8
    a_r8_extra_cycle: assert property (@(posedge clk) disable iff (rst)
        (drive_int && !dcd_lag && op_q == OP_IDLE) |=> (drive_int && $stable(rdata)));

    // R8
    a_r8_then_off: assert property (@(posedge clk) disable iff (rst)
        (dcd_lag && op_q != OP_READ) |=> !drive_int);

endmodule

bind pbw_sram pbw_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .op_q(op_q), .drive_int(drive_int), .dcd_lag(dcd_lag), .rdata(rdata)
);

// File: tb/pbw_sram_bench.sv
`timescale 1ns/1ps
module pbw_sram_bench;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int NV = 14;

    // entry: {kind[1:0], addr[5:0], lane_we_n[3:0], gw_n, data[35:0]}
    // kind 0 deselect, 1 read, 2 write with bw_en_n=0, 3 write attempt with bw_en_n=1
    localparam logic [48:0] VEC [NV] = '{
        {2'd2, 6'd5,  4'hF, 1'b0, 36'h123456789},
        {2'd2, 6'd9,  4'hF, 1'b0, 36'hFEDCBA987},
        {2'd1, 6'd5,  4'hF, 1'b1, 36'h0},
        {2'd1, 6'd9,  4'hF, 1'b1, 36'h0},
        {2'd2, 6'd5,  4'hE, 1'b1, 36'hAAAAAAAAA},
        {2'd1, 6'd5,  4'hF, 1'b1, 36'h0},
        {2'd2, 6'd9,  4'h5, 1'b1, 36'h555555555},
        {2'd1, 6'd9,  4'hF, 1'b1, 36'h0},
        {2'd2, 6'd5,  4'hF, 1'b0, 36'h00F0F0F0F},
        {2'd1, 6'd5,  4'hF, 1'b1, 36'h0},
        {2'd3, 6'd9,  4'h0, 1'b1, 36'h0},
        {2'd2, 6'd20, 4'h0, 1'b1, 36'h3C3C3C3C3},
        {2'd1, 6'd20, 4'hF, 1'b1, 36'h0},
        {2'd0, 6'd0,  4'hF, 1'b1, 36'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic [NL-1:0] lane_we_n = '1;
    logic          bw_en_n = 1'b1;
    logic          gw_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          drive;

    int nchk = 0;
    int nerr = 0;
    logic [DW-1:0] model [1 << AW];

    always #2.5 clk = ~clk;

    pbw_sram u_pbw_sram (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .lane_we_n(lane_we_n), .bw_en_n(bw_en_n), .gw_n(gw_n),
        .oe_n(oe_n), .rdata(rdata), .drive(drive)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic apply(input logic s1n, input logic s2, input logic s3n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [NL-1:0] wen, input logic bwe, input logic gw);
        sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        addr = a; wdata = d; lane_we_n = wen; bw_en_n = bwe; gw_n = gw;
        @(negedge clk);
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [NL-1:0] wen, input logic bwe, input logic gw);
        for (int l = 0; l < NL; l++)
            if (!gw || (!bwe && !wen[l]))
                model[a][l*LW +: LW] = d[l*LW +: LW];
    endtask

    task automatic desel();
        apply(1'b1, 1'b0, 1'b1, '0, '0, '1, 1'b1, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic          prev_rd;
        logic [DW-1:0] prev_exp;
        prev_rd  = 1'b0;
        prev_exp = '0;
        repeat (3) @(negedge clk);
        chk("R1 rdata after reset", rdata, '0);
        chk("R1 drive after reset", {35'b0, drive}, 36'd0);
        rst = 1'b0;

        // Table walk: writes update the mirror, reads are checked one step later.
        for (int i = 0; i < NV; i++) begin
            logic [1:0]    k;
            logic [AW-1:0] a;
            logic [NL-1:0] wen;
            logic          gw;
            logic [DW-1:0] d;
            logic          bwe;
            k   = VEC[i][48:47];
            a   = VEC[i][46:41];
            wen = VEC[i][40:37];
            gw  = VEC[i][36];
            d   = VEC[i][35:0];
            bwe = (k == 2'd2) ? 1'b0 : 1'b1;
            if (k == 2'd0)
                desel();
            else
                apply(1'b0, 1'b1, 1'b0, a, d, wen, bwe, gw);
            if (prev_rd) begin
                // R3 latency, R4/R5 lane merge, R6 disabled write, R10 write-then-read
                chk("R3/R4/R5/R6/R10 read data", rdata, prev_exp);
                chk("R3 drive on read", {35'b0, drive}, 36'd1);
            end
            if (k == 2'd2)
                model_write(a, d, wen, bwe, gw);
            prev_rd  = (k == 2'd1) || (k == 2'd3);
            prev_exp = model[a];
        end

        // R2: writes with an inactive select do nothing.
        apply(1'b0, 1'b0, 1'b0, 6'd5, '1, 4'h0, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b1, 6'd5, '1, 4'h0, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 6'd5, '1, 4'h0, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 6'd5, '0, 4'hF, 1'b1, 1'b1);
        desel();
        chk("R2 deselected write ignored", rdata, model[5]);
        chk("R3 drive after read", {35'b0, drive}, 36'd1);

        // R8: deselect after read holds drive one extra cycle.
        desel();
        chk("R8 drive held one cycle", {35'b0, drive}, 36'd1);
        chk("R8 rdata held", rdata, model[5]);
        desel();
        chk("R8 drive off after extra cycle", {35'b0, drive}, 36'd0);

        // R7: write right after a read turns drive off without the extra cycle.
        apply(1'b0, 1'b1, 1'b0, 6'd9, '0, 4'hF, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 1'b0, 6'd20, 36'h0000001FF, 4'hE, 1'b0, 1'b1);
        model_write(6'd20, 36'h0000001FF, 4'hE, 1'b0, 1'b1);
        chk("R7 read before write", rdata, model[9]);
        desel();
        chk("R7 drive off after write", {35'b0, drive}, 36'd0);

        // R9: asynchronous output enable, R10 follow-up on the merged word.
        apply(1'b0, 1'b1, 1'b0, 6'd20, '0, 4'hF, 1'b1, 1'b1);
        desel();
        chk("R10 merged word", rdata, model[20]);
        #1 oe_n = 1'b1;
        #0.5;
        chk("R9 oe high forces drive low", {35'b0, drive}, 36'd0);
        oe_n = 1'b0;
        #0.5;
        chk("R9 oe low restores drive", {35'b0, drive}, 36'd1);
        @(negedge clk);

        // R1: reset mid-run clears output and drive.
        rst = 1'b1;
        @(negedge clk);
        chk("R1 rdata after late reset", rdata, '0);
        chk("R1 drive after late reset", {35'b0, drive}, 36'd0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule